// File: doc/BRIEF.md
# Direct-Sequence Symbol-to-Chip Spreader

This block turns a baseband data stream into a direct-sequence chip stream for a quadrature transmitter. Incoming data arrives as bytes (or nibbles, chosen by a parameter) on a valid/ready handshake. Every four bits form one of sixteen data symbols. Each symbol is replaced by a fixed 32-chip pseudo-random code, and the chips leave one per pulse of a chip-rate enable.

The chip stream is split the way ordinary QPSK splits it. Chips in even positions of a code drive the in-phase output and chips in odd positions drive the quadrature output. Each output holds its value while the other one updates, which gives the one-chip offset that a following offset-QPSK modulator needs. The block takes a new symbol on the strobe that comes right after the last chip of the previous one, so a steady input gives a continuous chip stream.

Top module: `dsss_spreader`

## Requirements
- R1: While reset is asserted and after it is released, chip_valid, chip_i and chip_q are 0, and in_ready is 0 in any cycle where chip_en is 0.
- R2: in_ready is 1 only in a cycle where chip_en is 1 and no symbol is in flight, including a pending high nibble. A transfer takes place when in_valid and in_ready are both 1.
- R3: Symbol 0 spreads to the chips 11011001110000110101001000101110 (0xD9C3522E), sent leftmost first: chip k is bit 31-k of that word.
- R4: Symbol s, for s from 1 to 7, spreads to the symbol 0 code rotated right by 4·s chip positions, so its chip k equals chip (k-4·s) mod 32 of symbol 0.
- R5: Symbol s+8, for s from 0 to 7, spreads to the code of symbol s with every odd-indexed chip inverted.
- R6: Each symbol produces exactly 32 chips, one per chip_en strobe, in index order 0 to 31.
- R7: A chip with an even index updates chip_i, and a chip with an odd index updates chip_q. The other output keeps its value, so the two outputs never change in the same cycle.
- R8: chip_i, chip_q and chip_valid change only on the clock edge of a cycle in which chip_en is 1.
- R9: With byte input (IN_W = 8), bits [3:0] are spread first and bits [7:4] are spread second.
- R10: The next symbol, either the pending high nibble or a new transfer, starts on the first strobe after chip 31 of the current symbol, with no idle strobe between them.
- R11: On a strobe with no symbol in flight and no transfer, chip_valid goes to 0 and chip_i and chip_q keep their values.
- R12: chip_valid is 1 after every strobe that emits a chip, the first chip of a newly accepted symbol included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input data is offered |
| in_data | input | IN_W | Data byte (or nibble); low nibble is spread first |
| in_ready | output | 1 | Block takes in_data in this cycle (only on a strobe) |
| chip_en | input | 1 | Chip-rate strobe |
| chip_i | output | 1 | Even-indexed chip (in-phase) |
| chip_q | output | 1 | Odd-indexed chip (quadrature) |
| chip_valid | output | 1 | Chip outputs carry live chips |

## Verification
The first pass offers all 256 byte values back to back with a strobe in every cycle. It covers every symbol in both nibble positions, so an error in the base code, in a rotation or in the odd-chip inversion shows up as a wrong chip. It also shows any lost strobe or stall between symbols. The second pass strobes every third cycle and leaves idle stretches between bytes. This separates holding between strobes from updating at strobes, and it shows whether chip_valid drops correctly when no data is waiting. The readiness checks at every strobe show whether the nibble order and the start of the next symbol right after chip 31 behave as required.

// File: rtl/dsss_pkg.sv
package dsss_pkg;

    // Code geometry
    localparam int unsigned CHIPS_PER_SYM = 32;
    localparam int unsigned SYM_W         = 4;
    localparam int unsigned CHIP_IDX_W    = $clog2(CHIPS_PER_SYM);

    // Symbol 0 code, chip 0 in the MSB
    localparam logic [CHIPS_PER_SYM-1:0] BASE_CODE = 32'hD9C3522E;

    // Chip sequencer state
    typedef struct packed {
        logic                  busy;
        logic [SYM_W-1:0]      sym;
        logic [CHIP_IDX_W-1:0] idx;
        logic                  chip_i;
        logic                  chip_q;
        logic                  valid;
    } seq_state_t;

    // Byte splitter state
    typedef struct packed {
        logic             pending;
        logic [SYM_W-1:0] hi;
    } feed_state_t;

endpackage

// File: rtl/dsss_chip_table.sv
module dsss_chip_table #(
    parameter int unsigned                 CHIPS = dsss_pkg::CHIPS_PER_SYM,
    parameter int unsigned                 SYM_W = dsss_pkg::SYM_W,
    parameter logic [CHIPS-1:0]            BASE  = dsss_pkg::BASE_CODE
) (
    input  logic [SYM_W-1:0]               sym,
    input  logic [$clog2(CHIPS)-1:0]       idx,
    output logic                           chip
);

    localparam int unsigned IDX_W = $clog2(CHIPS);
    localparam int unsigned ROTS  = 2 ** (SYM_W - 1);
    localparam int unsigned STEP  = CHIPS / ROTS;

    logic [SYM_W-2:0] rot;
    logic [IDX_W-1:0] shift_amt;
    logic [IDX_W-1:0] src_idx;
    logic [IDX_W-1:0] bit_pos;
    logic             base_chip;

    always_comb begin
        rot       = sym[SYM_W-2:0];
        shift_amt = IDX_W'(rot) * IDX_W'(STEP);
        // rotating right: chip k comes from chip k - shift (mod CHIPS)
        src_idx   = idx - shift_amt;
        bit_pos   = IDX_W'(CHIPS - 1) - src_idx;
        base_chip = BASE[bit_pos];
        // upper half of the symbol set flips odd-indexed chips
        chip      = base_chip ^ (sym[SYM_W-1] & idx[0]);
    end

endmodule

// File: rtl/dsss_nibble_feed.sv
module dsss_nibble_feed #(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned SYM_W = dsss_pkg::SYM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic             slot_open,
    output logic             in_ready,
    output logic             load,
    output logic [SYM_W-1:0] load_sym
);

    import dsss_pkg::*;

    generate
        if (IN_W == 2 * SYM_W) begin : g_byte
            feed_state_t st_d, st_q;

            always_comb begin
                st_d     = st_q;
                in_ready = slot_open && !st_q.pending;
                load     = slot_open && (st_q.pending || in_valid);
                load_sym = st_q.pending ? st_q.hi : in_data[SYM_W-1:0];
                if (slot_open) begin
                    if (st_q.pending) begin
                        st_d.pending = 1'b0;
                    end else if (in_valid) begin
                        st_d.pending = 1'b1;
                        st_d.hi      = in_data[IN_W-1:SYM_W];
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end else begin : g_nibble
            always_comb begin
                in_ready = slot_open;
                load     = slot_open && in_valid;
                load_sym = in_data[SYM_W-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/dsss_chip_seq.sv
module dsss_chip_seq #(
    parameter int unsigned CHIPS = dsss_pkg::CHIPS_PER_SYM,
    parameter int unsigned SYM_W = dsss_pkg::SYM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             load,
    input  logic [SYM_W-1:0] load_sym,
    output logic             idle,
    output logic             chip_i,
    output logic             chip_q,
    output logic             chip_valid
);

    import dsss_pkg::*;

    localparam int unsigned IDX_W = $clog2(CHIPS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHIPS - 1);

    seq_state_t        st_d, st_q;
    logic [SYM_W-1:0]  cur_sym;
    logic [IDX_W-1:0]  cur_idx;
    logic              cur_chip;
    logic              emit;

    dsss_chip_table #(
        .CHIPS (CHIPS),
        .SYM_W (SYM_W)
    ) i_table (
        .sym  (cur_sym),
        .idx  (cur_idx),
        .chip (cur_chip)
    );

    always_comb begin
        st_d    = st_q;
        cur_sym = st_q.busy ? st_q.sym : load_sym;
        cur_idx = st_q.busy ? st_q.idx : '0;
        emit    = chip_en && (st_q.busy || load);

        if (emit) begin
            if (cur_idx[0]) begin
                st_d.chip_q = cur_chip;
            end else begin
                st_d.chip_i = cur_chip;
            end
            st_d.valid = 1'b1;
            st_d.sym   = cur_sym;
            if (cur_idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.busy = 1'b1;
                st_d.idx  = cur_idx + 1'b1;
            end
        end else if (chip_en) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle       = !st_q.busy;
    assign chip_i     = st_q.chip_i;
    assign chip_q     = st_q.chip_q;
    assign chip_valid = st_q.valid;

endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader #(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned CHIPS = dsss_pkg::CHIPS_PER_SYM,
    parameter int unsigned SYM_W = dsss_pkg::SYM_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_data,
    output logic            in_ready,
    input  logic            chip_en,
    output logic            chip_i,
    output logic            chip_q,
    output logic            chip_valid
);

    logic             seq_idle;
    logic             slot_open;
    logic             load;
    logic [SYM_W-1:0] load_sym;

    assign slot_open = chip_en && seq_idle;

    dsss_nibble_feed #(
        .IN_W  (IN_W),
        .SYM_W (SYM_W)
    ) i_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .slot_open (slot_open),
        .in_ready  (in_ready),
        .load      (load),
        .load_sym  (load_sym)
    );

    dsss_chip_seq #(
        .CHIPS (CHIPS),
        .SYM_W (SYM_W)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_en    (chip_en),
        .load       (load),
        .load_sym   (load_sym),
        .idle       (seq_idle),
        .chip_i     (chip_i),
        .chip_q     (chip_q),
        .chip_valid (chip_valid)
    );

endmodule

// File: rtl/dsss_spreader_chk.sv
module dsss_spreader_chk #(
    parameter int unsigned CHIPS = dsss_pkg::CHIPS_PER_SYM
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic chip_en,
    input logic chip_i,
    input logic chip_q,
    input logic chip_valid
);

    localparam int unsigned CNT_W = $clog2(CHIPS) + 1;

    // chips still owed by the most recently accepted symbol
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (in_valid && in_ready) begin
            remain_q <= CNT_W'(CHIPS - 1);
        end else if (chip_en && remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // R8
    outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> ($stable(chip_i) && $stable(chip_q) && $stable(chip_valid)));

    // R2
    ready_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> chip_en);

    // R12
    valid_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> chip_valid);

    // R7
    single_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((chip_i != $past(chip_i)) && (chip_q != $past(chip_q))));

    // R6
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (remain_q != '0) |-> !in_ready);

endmodule

bind dsss_spreader dsss_spreader_chk #(.CHIPS(CHIPS)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .chip_en    (chip_en),
    .chip_i     (chip_i),
    .chip_q     (chip_q),
    .chip_valid (chip_valid)
);

// File: tb/test_dsss_spreader.sv
module test_dsss_spreader;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic       chip_en = 1'b0;
    logic       chip_i;
    logic       chip_q;
    logic       chip_valid;

    int tests = 0;
    int fails = 0;

    // reference model
    logic [3:0] exp_sym [0:1023];
    int  m_cnt = 0;
    int  m_head = 0;
    int  m_idx = 0;
    logic m_i = 1'b0, m_q = 1'b0, m_v = 1'b0;
    logic acc;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsss_spreader i_dsss_spreader (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .chip_en    (chip_en),
        .chip_i     (chip_i),
        .chip_q     (chip_q),
        .chip_valid (chip_valid)
    );

    function automatic logic ref_chip(input logic [3:0] s, input int k);
        logic [31:0] code;
        int sh;
        sh   = 4 * int'(s[2:0]);
        code = 32'hD9C3522E;                      // R3
        if (sh != 0) code = (code >> sh) | (code << (32 - sh));  // R4
        if (s[3]) code = code ^ 32'h55555555;     // R5
        return code[31 - k];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic v, input logic [7:0] d);
        string tag;
        logic  rdy_exp;
        @(negedge clk);
        chip_en  = en;
        in_valid = v;
        in_data  = d;
        #1;
        rdy_exp = en && (m_head == m_cnt);
        check(en ? "R2 R10 in_ready at strobe" : "R1 R2 in_ready off strobe",
              32'(in_ready), 32'(rdy_exp));
        acc = in_valid && in_ready;
        if (acc) begin
            exp_sym[m_cnt]     = d[3:0];          // R9 low nibble first
            exp_sym[m_cnt + 1] = d[7:4];
            m_cnt += 2;
        end
        if (!en) begin
            tag = "R8 hold between strobes";
        end else if (m_head < m_cnt) begin
            logic c;
            c = ref_chip(exp_sym[m_head], m_idx);
            if (m_idx % 2 == 1) m_q = c; else m_i = c;
            m_v = 1'b1;
            tag = $sformatf("%s R6 R7 R9 R12 sym=%0d chip=%0d",
                            exp_sym[m_head] == 0 ? "R3" :
                            (exp_sym[m_head] < 8 ? "R4" : "R5"),
                            exp_sym[m_head], m_idx);
            m_idx++;
            if (m_idx == 32) begin
                m_idx = 0;
                m_head++;
            end
        end else begin
            m_v = 1'b0;
            tag = "R11 idle strobe";
        end
        @(posedge clk);
        #1;
        check(tag, {29'd0, chip_valid, chip_i, chip_q}, {29'd0, m_v, m_i, m_q});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 outputs in reset", {29'd0, chip_valid, chip_i, chip_q}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 outputs after reset", {29'd0, chip_valid, chip_i, chip_q}, 32'd0);
        step(1'b0, 1'b1, 8'h00);   // R1: no strobe, no transfer
        step(1'b1, 1'b0, 8'h00);   // R11: idle strobe

        // pass 1: every byte, strobe each cycle, back to back (R10)
        for (int b = 0; b < 256; b++) begin
            acc = 1'b0;
            while (!acc) step(1'b1, 1'b1, 8'(b));
        end
        while (m_head < m_cnt) step(1'b1, 1'b0, 8'h00);
        step(1'b1, 1'b0, 8'h00);   // R11 after drain

        // pass 2: sparse strobes with idle gaps
        for (int n = 0; n < 16; n++) begin
            int k;
            logic [7:0] byt;
            byt = 8'(n * 37) ^ 8'h5A;
            k = 0;
            acc = 1'b0;
            while (!acc) begin
                step(k % 3 == 0, 1'b1, byt);
                k++;
            end
            while (m_head < m_cnt) begin
                step(k % 3 == 0, 1'b0, 8'h00);
                k++;
            end
            for (int g = 0; g < 6; g++) step(g % 3 == 0, 1'b0, 8'h00);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule